// File: doc/BRIEF.md
# Multi-channel DMA descriptor queue

This block sits between software and a transfer engine. Software stages a transfer descriptor through a word-addressed register port. The descriptor holds a source address, a destination address and a size word. Writing the channel index then appends the staged descriptor to that channel's queue. Each channel keeps its own queue of descriptors. It offers the oldest one to the engine on a per-channel valid/ready port, keeps at most one descriptor in flight, and waits for a completion pulse before it offers the next. Choosing between channels and moving the data are left to the engine.

Each channel has a control word with these parts:
- enable, pause and priority fields that software writes;
- fill level, full flag and pending count, which are read-only;
- a low-watermark threshold.

Each channel also has a terminal-count register. Two global status words carry one sticky bit per channel, one for low-watermark events and one for terminal-count events. Each word drives its own interrupt line. A commit that cannot be accepted is dropped and sets a sticky overflow flag.

Stopping a channel takes a handshake. Software clears the enable bit, and the bit keeps reading 1 until any descriptor in flight has completed. A flag in the size word can also make a channel turn itself off after that descriptor completes.

Top module: `dmaq`

## Requirements
- R1: Writes to word addresses 0x00, 0x01 and 0x02 stage the source, destination and size. A write of the channel index to 0x03 appends them to that channel's queue. Each channel offers its descriptors in the order they were committed, with the source, the destination and size bits 23:0 on its engine port.
- R2: A channel raises its offer when all of these hold: it is enabled, not paused, its queue is not empty, and no descriptor is in flight. The offer holds steady until ready is seen. The handshake removes the descriptor from the queue and blocks further offers until that channel's completion pulse.
- R3: A commit is dropped, and bit 0 of the status word at 0x04 is set, in either of two cases: the index is not below the channel count, or the target queue already holds 16 entries. The fill is taken before any pop in the same cycle. The flag stays set until a 1 is written to bit 0 of 0x04.
- R4: Channel c has its control word at 0x10+4c. The writable fields are enable (bit 0), pause (bit 1), priority (bits 3:2) and low-watermark threshold (bits 29:26); they read back as written. The read-only fields are fill level (bits 16:12), full (bit 17, set at 16 entries) and pending count (bits 25:20, equal to fill plus the descriptor in flight).
- R5: A low-watermark event happens when a pop takes a channel's fill from above its threshold to at or below it. The event sets bit c of the word at 0x06. Writing 1 to that bit clears it. irq_lowmark is the OR of the bits.
- R6: The terminal-count register of channel c sits at 0x11+4c. It holds 16 bits and resets to 1; a value of 0 acts as 1. After that many completions, bit c of the word at 0x05 is set and the count starts over. Writing the register also restarts the count. Writing 1 to a status bit clears it. irq_term is the OR of the bits.
- R7: Writing enable=0 to an idle channel clears the enable bit at once. If a descriptor is in flight, the enable bit keeps reading 1 and nothing new is offered. The bit clears on that descriptor's completion.
- R8: A descriptor whose size word has bit 24 set clears its channel's enable bit when it completes. The descriptors behind it stay queued.
- R9: After reset:
  - every queue is empty;
  - every control field is 0;
  - every terminal-count register reads 1;
  - the status words and both interrupts are 0;
  - no offer is raised.
- R10: While pause is 1, nothing is offered and the queue is left unchanged. Clearing pause resumes offers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Register write word address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | AW | Register read word address |
| rd_data | output | 32 | Register read data (combinational) |
| xfer_valid | output | NCH | Per-channel descriptor offer |
| xfer_ready | input | NCH | Per-channel acceptance from the engine |
| xfer_src | output | NCH*32 | Per-channel source address |
| xfer_dst | output | NCH*32 | Per-channel destination address |
| xfer_len | output | NCH*LENW | Per-channel transfer length |
| xfer_done | input | NCH | Per-channel completion pulse |
| irq_lowmark | output | 1 | Any low-watermark status bit set |
| irq_term | output | 1 | Any terminal-count status bit set |

## Verification
Every register write, handshake and completion pulse changes state at the clock edge where it is sampled. Reads are combinational, so each result can be seen in the half cycle after that edge:
- the fill and pending fields;
- the offer, the status bits and the interrupts;
- the enable bit.

The bench applies writes at the falling edge, and applies ready and completion pulses just after a rising edge. It reads registers and ports only at the following falling edge. The scoreboard monitor compares each descriptor at the falling edge before the rising edge that accepts it.

// File: rtl/dmaq.sv
module dmaq #(
  parameter int NCH   = 4,
  parameter int DEPTH = 16,
  parameter int AW    = 8,
  parameter int LENW  = 24
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [AW-1:0]        wr_addr,
  input  logic [31:0]          wr_data,
  input  logic [AW-1:0]        rd_addr,
  output logic [31:0]          rd_data,
  output logic [NCH-1:0]       xfer_valid,
  input  logic [NCH-1:0]       xfer_ready,
  output logic [NCH*32-1:0]    xfer_src,
  output logic [NCH*32-1:0]    xfer_dst,
  output logic [NCH*LENW-1:0]  xfer_len,
  input  logic [NCH-1:0]       xfer_done,
  output logic                 irq_lowmark,
  output logic                 irq_term
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int ADIS_BIT = 24;
  localparam logic [AW-1:0] A_SRC  = AW'(0);
  localparam logic [AW-1:0] A_DST  = AW'(1);
  localparam logic [AW-1:0] A_SIZE = AW'(2);
  localparam logic [AW-1:0] A_CHAN = AW'(3);
  localparam logic [AW-1:0] A_OVF  = AW'(4);
  localparam logic [AW-1:0] A_TCST = AW'(5);
  localparam logic [AW-1:0] A_LWST = AW'(6);
  localparam int A_CH0 = 16;

  logic [31:0] stg_src, stg_dst, stg_size;
  logic        ovf;
  logic [NCH-1:0] full_v, en_v, busy_v, tc_v, lw_v;
  logic [31:0] ctrl_rd [NCH];
  logic [15:0] tcl_rd  [NCH];
  logic        sel_full;

  wire commit  = wr_en && wr_addr == A_CHAN;
  wire chan_ok = wr_data < 32'(NCH);

  always_comb begin
    sel_full = 1'b0;
    for (int c = 0; c < NCH; c++)
      if (wr_data == 32'(c)) sel_full = full_v[c];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stg_src <= '0; stg_dst <= '0; stg_size <= '0; ovf <= 1'b0;
    end else begin
      if (wr_en && wr_addr == A_SRC)  stg_src  <= wr_data;
      if (wr_en && wr_addr == A_DST)  stg_dst  <= wr_data;
      if (wr_en && wr_addr == A_SIZE) stg_size <= wr_data;
      if (wr_en && wr_addr == A_OVF && wr_data[0]) ovf <= 1'b0;
      if (commit && (!chan_ok || sel_full)) ovf <= 1'b1;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam logic [AW-1:0] A_CTL = AW'(A_CH0 + 4*c);
    localparam logic [AW-1:0] A_TCL = AW'(A_CH0 + 4*c + 1);

    logic [31:0]   m_src [DEPTH];
    logic [31:0]   m_dst [DEPTH];
    logic [LENW:0] m_len [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          en, stop, pause, busy, adis, tc_st, lw_st;
    logic [1:0]    prio;
    logic [3:0]    lwm;
    logic [15:0]   tc_lim, tc_cnt;

    wire push   = commit && wr_data == 32'(c) && cnt != CW'(DEPTH);
    wire offer  = en && !stop && !pause && !busy && cnt != '0;
    wire pop    = offer && xfer_ready[c];
    wire ctl_wr = wr_en && wr_addr == A_CTL;
    wire tcl_wr = wr_en && wr_addr == A_TCL;
    wire done_ev = xfer_done[c] && busy;
    wire [CW-1:0] cnt_nx = cnt + CW'(push) - CW'(pop);
    wire lw_hit = 32'(cnt_nx) <= 32'(lwm) && 32'(cnt) > 32'(lwm);
    wire tc_hit = done_ev && !tcl_wr && (tc_lim == '0 || tc_cnt + 16'd1 >= tc_lim);

    always_ff @(posedge clk) begin
      if (push) begin
        m_src[wp] <= stg_src;
        m_dst[wp] <= stg_dst;
        m_len[wp] <= {stg_size[ADIS_BIT], stg_size[LENW-1:0]};
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        wp <= '0; rp <= '0; cnt <= '0;
        en <= 1'b0; stop <= 1'b0; pause <= 1'b0; busy <= 1'b0; adis <= 1'b0;
        prio <= '0; lwm <= '0; tc_lim <= 16'd1; tc_cnt <= '0;
        tc_st <= 1'b0; lw_st <= 1'b0;
      end else begin
        cnt <= cnt_nx;
        if (push) wp <= wp + PW'(1);
        if (pop) begin
          rp   <= rp + PW'(1);
          busy <= 1'b1;
          adis <= m_len[rp][LENW];
        end
        if (ctl_wr) begin
          pause <= wr_data[1];
          prio  <= wr_data[3:2];
          lwm   <= wr_data[29:26];
          if (wr_data[0]) begin
            en <= 1'b1; stop <= 1'b0;
          end else if (busy || pop) begin
            stop <= 1'b1;
          end else begin
            en <= 1'b0; stop <= 1'b0;
          end
        end
        if (done_ev) begin
          busy <= 1'b0;
          if (stop || adis || (ctl_wr && !wr_data[0])) begin
            en <= 1'b0; stop <= 1'b0;
          end
        end
        if (tcl_wr) begin
          tc_lim <= wr_data[15:0];
          tc_cnt <= '0;
        end else if (done_ev) begin
          tc_cnt <= tc_hit ? '0 : tc_cnt + 16'd1;
        end
        if (wr_en && wr_addr == A_TCST && wr_data[c]) tc_st <= 1'b0;
        if (tc_hit) tc_st <= 1'b1;
        if (wr_en && wr_addr == A_LWST && wr_data[c]) lw_st <= 1'b0;
        if (lw_hit) lw_st <= 1'b1;
      end
    end

    assign full_v[c] = cnt == CW'(DEPTH);
    assign en_v[c]   = en;
    assign busy_v[c] = busy;
    assign tc_v[c]   = tc_st;
    assign lw_v[c]   = lw_st;
    assign ctrl_rd[c] = {2'b00, lwm, 6'(cnt) + 6'(busy), 2'b00, full_v[c],
                         5'(cnt), 8'h00, prio, pause, en};
    assign tcl_rd[c]  = tc_lim;
    assign xfer_valid[c]             = offer;
    assign xfer_src[c*32 +: 32]      = m_src[rp];
    assign xfer_dst[c*32 +: 32]      = m_dst[rp];
    assign xfer_len[c*LENW +: LENW]  = m_len[rp][LENW-1:0];
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == A_SRC)  rd_data = stg_src;
    if (rd_addr == A_DST)  rd_data = stg_dst;
    if (rd_addr == A_SIZE) rd_data = stg_size;
    if (rd_addr == A_OVF)  rd_data = {31'b0, ovf};
    if (rd_addr == A_TCST) rd_data = 32'(tc_v);
    if (rd_addr == A_LWST) rd_data = 32'(lw_v);
    for (int c = 0; c < NCH; c++) begin
      if (rd_addr == AW'(A_CH0 + 4*c))     rd_data = ctrl_rd[c];
      if (rd_addr == AW'(A_CH0 + 4*c + 1)) rd_data = {16'h0000, tcl_rd[c]};
    end
  end

  assign irq_lowmark = |lw_v;
  assign irq_term    = |tc_v;
endmodule

// File: rtl/dmaq_chk.sv
module dmaq_chk #(
  parameter int NCH = 4,
  parameter int AW  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [AW-1:0]     wr_addr,
  input logic              clr_bit,
  input logic [NCH-1:0]    xfer_valid,
  input logic [NCH-1:0]    xfer_ready,
  input logic [NCH*32-1:0] xfer_src,
  input logic [NCH-1:0]    xfer_done,
  input logic [NCH-1:0]    en_v,
  input logic [NCH-1:0]    busy_v,
  input logic [NCH-1:0]    full_v,
  input logic              ovf,
  input logic              irq_term
);
  localparam logic [AW-1:0] A_OVF  = AW'(4);
  localparam logic [AW-1:0] A_TCST = AW'(5);

  assert_ovf_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !(wr_en && wr_addr == A_OVF && clr_bit)) |=> ovf);

  assert_term_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_term) |-> $past(wr_en && wr_addr == A_TCST));

  for (genvar c = 0; c < NCH; c++) begin : g_c
    assert_one_inflight_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_valid[c] && xfer_ready[c]) |=> (!xfer_valid[c] && busy_v[c]));

    assert_offer_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_valid[c] && !xfer_ready[c] && !wr_en) |=>
        (xfer_valid[c] && $stable(xfer_src[c*32 +: 32])));

    assert_stop_waits_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (en_v[c] && busy_v[c] && !xfer_done[c]) |=> en_v[c]);

    assert_full_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (full_v[c] && !(xfer_valid[c] && xfer_ready[c])) |=> full_v[c]);
  end
endmodule

bind dmaq dmaq_chk #(.NCH(NCH), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .clr_bit(wr_data[0]),
  .xfer_valid(xfer_valid), .xfer_ready(xfer_ready), .xfer_src(xfer_src),
  .xfer_done(xfer_done), .en_v(en_v), .busy_v(busy_v), .full_v(full_v),
  .ovf(ovf), .irq_term(irq_term)
);

// File: tb/tb_dmaq.sv
`timescale 1ns/100ps
module tb_dmaq;
  localparam int NCH = 4, LENW = 24, AW = 8;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, wr_en, irq_lowmark, irq_term;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [31:0] wr_data, rd_data;
  logic [NCH-1:0] xfer_valid, xfer_ready, xfer_done;
  logic [NCH*32-1:0] xfer_src, xfer_dst;
  logic [NCH*LENW-1:0] xfer_len;

  dmaq dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .xfer_valid(xfer_valid), .xfer_ready(xfer_ready),
    .xfer_src(xfer_src), .xfer_dst(xfer_dst), .xfer_len(xfer_len), .xfer_done(xfer_done),
    .irq_lowmark(irq_lowmark), .irq_term(irq_term));

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;
  logic [89:0] expq[$];
  logic [31:0] v;

  task automatic chk(input bit ok, input string req, input logic [95:0] act, input logic [95:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wrreg(input int a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rdreg(input int a, output logic [31:0] d);
    @(negedge clk); rd_addr = AW'(a); #1; d = rd_data;
  endtask

  task automatic commit(input int c, input logic [31:0] s, input logic [31:0] dd,
                        input logic [31:0] z, input bit ok);
    wrreg(0, s); wrreg(1, dd); wrreg(2, z);
    if (ok) expq.push_back({c[1:0], s, dd, z[23:0]});
    wrreg(3, c);
  endtask

  task automatic issue(input int c);
    int w = 0;
    @(negedge clk);
    while (!xfer_valid[c] && w < 50) begin @(negedge clk); w++; end
    if (!xfer_valid[c]) begin
      chk(1'b0, "R2 offer never raised", 0, 1);
    end else begin
      @(posedge clk); #1 xfer_ready[c] = 1'b1;
      @(posedge clk); #1 xfer_ready[c] = 1'b0;
    end
  endtask

  task automatic complete(input int c);
    @(posedge clk); #1 xfer_done[c] = 1'b1;
    @(posedge clk); #1 xfer_done[c] = 1'b0;
  endtask

  // scoreboard monitor: compares each offered descriptor before the accepting edge
  always @(negedge clk) begin
    for (int c = 0; c < NCH; c++) begin
      if (rst_n && xfer_valid[c] && xfer_ready[c]) begin
        logic [89:0] act, e;
        act = {c[1:0], xfer_src[c*32 +: 32], xfer_dst[c*32 +: 32], xfer_len[c*LENW +: LENW]};
        if (expq.size() == 0) chk(1'b0, "R1 unexpected descriptor", 96'(act), 0);
        else begin
          e = expq.pop_front();
          chk(act == e, "R1 descriptor order/content", 96'(act), 96'(e));
        end
      end
    end
  end

  initial begin
    #(100000 * 5);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    xfer_ready = '0; xfer_done = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R9 reset state
    rdreg(16'h10, v); chk(v == 0, "R9 ctrl reset", v, 0);
    rdreg(16'h11, v); chk(v == 1, "R9 term count reset", v, 1);
    rdreg(4, v);      chk(v == 0, "R9 overflow reset", v, 0);
    rdreg(5, v);      chk(v == 0, "R9 tc status reset", v, 0);
    rdreg(6, v);      chk(v == 0, "R9 lw status reset", v, 0);
    chk(!irq_term && !irq_lowmark && xfer_valid == 0, "R9 outputs idle",
        {irq_term, irq_lowmark, xfer_valid}, 0);

    // ch1: three descriptors while disabled
    commit(1, 32'h1000_0000, 32'h2000_0000, 32'h0000_0100, 1'b1);
    commit(1, 32'h1000_0040, 32'h2000_0040, 32'h0000_0200, 1'b1);
    commit(1, 32'h1000_0080, 32'h2000_0080, 32'h0000_0300, 1'b1);
    rdreg(16'h14, v); chk(v == ((3 << 12) | (3 << 20)), "R4 fill/pending while disabled", v, (3 << 12) | (3 << 20));
    chk(xfer_valid[1] == 1'b0, "R2 no offer while disabled", xfer_valid[1], 0);
    wrreg(16'h14, 32'h1 | 32'h8 | (1 << 26));
    rdreg(16'h14, v);
    chk(v == (32'h9 | (3 << 12) | (3 << 20) | (1 << 26)), "R4 control readback", v,
        32'h9 | (3 << 12) | (3 << 20) | (1 << 26));
    chk(xfer_valid[1] == 1'b1, "R2 offer when enabled", xfer_valid[1], 1);

    issue(1);
    rdreg(16'h14, v); chk(v[25:12] == {6'd3, 3'b0, 5'd2}, "R4 pending counts in-flight", v[25:12], {6'd3, 3'b0, 5'd2});
    chk(xfer_valid[1] == 1'b0, "R2 one in flight", xfer_valid[1], 0);
    rdreg(6, v); chk(v == 0, "R5 no event above mark", v, 0);
    complete(1);
    @(negedge clk);
    chk(irq_term == 1'b1, "R6 term irq after 1 completion", irq_term, 1);
    rdreg(5, v); chk(v == 2, "R6 status bit of ch1", v, 2);
    wrreg(5, 32'hF);
    chk(irq_term == 1'b0, "R6 clear by write-one", irq_term, 0);

    issue(1);
    rdreg(6, v); chk(v == 2, "R5 event at threshold", v, 2);
    chk(irq_lowmark == 1'b1, "R5 lowmark irq", irq_lowmark, 1);
    wrreg(6, 32'h2);
    chk(irq_lowmark == 1'b0, "R5 clear by write-one", irq_lowmark, 0);
    complete(1); wrreg(5, 32'hF);

    // R10 pause
    wrreg(16'h14, 32'hB | (1 << 26));
    chk(xfer_valid[1] == 1'b0, "R10 paused no offer", xfer_valid[1], 0);
    rdreg(16'h14, v); chk(v[16:12] == 5'd1, "R10 queue unchanged", v[16:12], 1);
    wrreg(16'h14, 32'h9 | (1 << 26));
    chk(xfer_valid[1] == 1'b1, "R10 resume", xfer_valid[1], 1);

    // R7 stop while busy
    issue(1);
    wrreg(16'h14, 32'h8 | (1 << 26));
    rdreg(16'h14, v); chk(v[0] == 1'b1, "R7 enable holds while busy", v[0], 1);
    commit(1, 32'h1000_00C0, 32'h2000_00C0, 32'h0000_0400, 1'b1);
    chk(xfer_valid[1] == 1'b0, "R7 no offer while stopping", xfer_valid[1], 0);
    complete(1);
    rdreg(16'h14, v); chk(v[0] == 1'b0 && v[16:12] == 5'd1, "R7 enable clears on completion",
                          {v[16:12], v[0]}, {5'd1, 1'b0});
    wrreg(16'h14, 32'h9);
    issue(1); complete(1);
    wrreg(16'h14, 32'h8);
    rdreg(16'h14, v); chk(v[0] == 1'b0, "R7 idle disable immediate", v[0], 0);
    wrreg(5, 32'hF); wrreg(6, 32'hF);

    // R3 overflow on ch2
    for (int k = 0; k < 16; k++)
      commit(2, 32'h3000_0000 + 32'(k * 16), 32'h4000_0000 + 32'(k * 16), 32'(k + 1), 1'b1);
    rdreg(16'h18, v); chk(v == ((16 << 12) | (1 << 17) | (16 << 20)), "R3 full at 16", v,
                          (16 << 12) | (1 << 17) | (16 << 20));
    commit(2, 32'hDEAD_0000, 32'hDEAD_0000, 32'h99, 1'b0);
    rdreg(4, v); chk(v == 1, "R3 overflow on full", v, 1);
    rdreg(16'h18, v); chk(v[16:12] == 5'd16, "R3 dropped commit", v[16:12], 16);
    wrreg(4, 1);
    rdreg(4, v); chk(v == 0, "R3 overflow cleared", v, 0);
    commit(7, 32'hBEEF_0000, 32'hBEEF_0000, 32'h1, 1'b0);
    rdreg(4, v); chk(v == 1, "R3 overflow bad channel", v, 1);
    wrreg(4, 1);

    // R6 terminal count of 5, and ordered drain (R1)
    wrreg(16'h19, 5);
    rdreg(16'h19, v); chk(v == 5, "R6 term count readback", v, 5);
    wrreg(16'h18, 1);
    for (int k = 0; k < 16; k++) begin
      issue(2); complete(2);
      if (k == 3) begin rdreg(5, v); chk(v[2] == 1'b0, "R6 no event before limit", v[2], 0); end
      if (k == 4) begin
        rdreg(5, v); chk(v[2] == 1'b1, "R6 event at limit", v[2], 1);
        wrreg(5, 32'hF);
      end
    end
    chk(expq.size() == 0, "R1 all ch2 descriptors delivered", expq.size(), 0);

    // R8 auto-disable on ch3
    wrreg(16'h1C, 1);
    commit(3, 32'h5000_0000, 32'h6000_0000, 32'h0100_0040, 1'b1);
    commit(3, 32'h5000_1000, 32'h6000_1000, 32'h0000_0080, 1'b1);
    issue(3); complete(3);
    rdreg(16'h1C, v); chk(v[0] == 1'b0 && v[16:12] == 5'd1, "R8 auto-disable keeps queue",
                          {v[16:12], v[0]}, {5'd1, 1'b0});
    chk(xfer_valid[3] == 1'b0, "R8 no offer after auto-disable", xfer_valid[3], 0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule